// File: doc/BRIEF.md
# Transition Write Encoder

This block drives the serial write-data line of a magnetic disk with transition encoding. Each event is a single flip of the output level, never a pulse of fixed width. A start request raises write gate at once. The line then stays quiet for a lead-in period, so that the erase head reaches the point where writing is about to begin. After the lead-in, the encoder places a clock transition at the start of every bit cell. When the cell's data bit is 1, it adds a second transition halfway through the cell.

Bits arrive from an upstream serializer through a request handshake. The encoder pulses a request for one cycle at each clock transition. The serializer answers by presenting the next bit, and the encoder latches that bit before the mid-cell point. A stop request lets the current cell run to its end. At that boundary the encoder drops write gate and returns the line to 0. The cell length and the lead-in length are given in nanoseconds. They are turned into cycle counts from the system clock frequency.

Top module: `flux_write_encoder`

## Requirements
- R1: After reset, and in every cycle where `write_gate` is low, `write_data` and `bit_req` are 0.
- R2: A `start` sampled while idle raises `write_gate` at that edge. `write_data` holds 0 for the whole lead-in. The first transition comes exactly LEAD_CYC = CLK_MHZ*LEAD_NS/1000 edges after the start edge (500 with the defaults, 2 µs at 250 MHz).
- R3: While writing, a clock transition occurs every CELL_CYC = CLK_MHZ*CELL_NS/1000 edges (150 with the defaults, 600 ns).
- R4: When a cell's bit is 1, `write_data` toggles once more, HALF_CYC = CELL_CYC/2 edges after that cell's clock transition. A 0 bit adds no transition in that cell.
- R5: `bit_req` is high for exactly one cycle, the cycle in which the output first shows each clock transition, and it is never high at any other time.
- R6: `bit_in` is sampled at the end of the cycle that follows the `bit_req` cycle. Later changes to `bit_in` within the same cell have no effect.
- R7: A `stop` seen during a cell, including at its final edge, ends writing at the next cell boundary. At that boundary no clock transition and no `bit_req` is given, `write_gate` falls and `write_data` goes to 0. A `stop` during the lead-in returns the block to idle at that edge. A `stop` while idle is ignored.
- R8: A `start` while `write_gate` is high is ignored and does not disturb the cell timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a write, sampled while idle |
| stop | input | 1 | End the write at the next cell boundary |
| bit_in | input | 1 | Next data bit from the serializer |
| write_gate | output | 1 | Write enable to the drive |
| write_data | output | 1 | Transition-encoded write line |
| bit_req | output | 1 | One-cycle request for the next bit |

## Verification
Each result falls at a fixed distance from the edge that caused it. Write gate changes at the start edge itself. The first transition comes LEAD_CYC edges later. Each later clock transition follows the previous one by CELL_CYC edges, and the data transition follows its clock transition by HALF_CYC edges. The bit is taken two edges after the clock transition. The bench keeps its own edge counter and works out, for every edge, which of these events falls due. It compares all three outputs at the falling clock edge that follows. It also spoils `bit_in` once the sampling edge has passed, so that a late sample shows up as a wrong data transition.

// File: rtl/flux_write_encoder.sv
module flux_write_encoder #(
  parameter int CLK_MHZ = 250,
  parameter int CELL_NS = 600,
  parameter int LEAD_NS = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  input  logic bit_in,
  output logic write_gate,
  output logic write_data,
  output logic bit_req
);
  localparam int CELL_CYC = CLK_MHZ * CELL_NS / 1000;
  localparam int HALF_CYC = CELL_CYC / 2;
  localparam int LEAD_CYC = CLK_MHZ * LEAD_NS / 1000;
  localparam int MAX_CYC  = (LEAD_CYC > CELL_CYC) ? LEAD_CYC : CELL_CYC;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_CELL} state_t;

  state_t     st;
  logic [CNT_W-1:0] cnt;
  logic       cur_bit, stop_pend;

  wire lead_done = cnt == CNT_W'(LEAD_CYC - 1);
  wire cell_end  = cnt == CNT_W'(CELL_CYC - 1);
  wire mid_cell  = cnt == CNT_W'(HALF_CYC - 1);
  wire take_bit  = cnt == CNT_W'(1);
  wire finish    = stop_pend | stop;

  assign write_gate = st != S_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      write_data <= 1'b0;
      bit_req    <= 1'b0;
      cur_bit    <= 1'b0;
      stop_pend  <= 1'b0;
    end else begin
      bit_req <= 1'b0;
      case (st)
        S_IDLE: begin
          write_data <= 1'b0;
          cnt        <= '0;
          stop_pend  <= 1'b0;
          if (start) st <= S_LEAD;
        end
        S_LEAD: begin
          if (stop) begin
            st <= S_IDLE;
          end else if (lead_done) begin
            st         <= S_CELL;
            cnt        <= '0;
            write_data <= ~write_data;
            bit_req    <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_CELL: begin
          if (stop) stop_pend <= 1'b1;
          if (cell_end) begin
            cnt <= '0;
            if (finish) begin
              st         <= S_IDLE;
              write_data <= 1'b0;
              stop_pend  <= 1'b0;
            end else begin
              write_data <= ~write_data;
              bit_req    <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
            if (take_bit) cur_bit <= bit_in;
            if (mid_cell && cur_bit) write_data <= ~write_data;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module flux_write_encoder_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic write_gate,
  input logic write_data,
  input logic bit_req
);
  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !write_gate |-> !write_data);
  a_r1_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !write_gate |-> !bit_req);
  a_r2_gate_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!write_gate && start) |=> write_gate);
  a_r2_quiet_leadin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(write_gate) |-> !write_data);
  a_r5_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    bit_req |=> !bit_req);
  a_r5_req_on_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    bit_req |-> (write_data != $past(write_data)));
  a_r7_end_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(write_gate) |-> !write_data);
endmodule

bind flux_write_encoder flux_write_encoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .write_gate(write_gate), .write_data(write_data), .bit_req(bit_req)
);

// File: tb/flux_write_encoder_test.sv
module flux_write_encoder_test;
  localparam int CELL = 150, HALF = 75, LEAD = 500;

  logic clk = 0, rst_n = 0, start = 0, stop = 0, bit_in = 0;
  logic write_gate, write_data, bit_req;
  int checks = 0, errors = 0;

  flux_write_encoder uut (.*);

  always #2 clk = ~clk;

  bit pat [64];
  int n = 0;
  int mode = 0;
  int t0 = 0;
  int idx = 0;
  int d;
  bit m_wg = 0, m_wd = 0, m_req = 0, m_bit = 0, m_stop = 0;

  always @(posedge clk) begin
    n++;
    m_req = 0;
    if (rst_n) begin
      if (mode == 0) begin
        if (start) begin mode = 1; t0 = n + LEAD; m_wg = 1; end
      end else if (mode == 1) begin
        if (stop) begin mode = 0; m_wg = 0; m_wd = 0; end
        else if (n == t0) begin
          mode = 2; m_wd = ~m_wd; m_req = 1; m_bit = pat[idx % 64]; idx++;
        end
      end else begin
        d = n - t0;
        if (stop) m_stop = 1;
        if (d % CELL == 0) begin
          if (m_stop) begin mode = 0; m_wg = 0; m_wd = 0; m_stop = 0; end
          else begin m_wd = ~m_wd; m_req = 1; m_bit = pat[idx % 64]; idx++; end
        end else if (d % CELL == HALF && m_bit) m_wd = ~m_wd;
      end
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at edge %0d: actual %0d expected %0d", what, n, act, exp);
    end
  endtask

  int drv_idx = 0, spoil = 0;
  bit run_cmp = 0;
  always @(negedge clk) begin
    if (run_cmp) begin
      check(write_gate == m_wg, "R2 R7 R8 write_gate", write_gate, m_wg);
      check(write_data == m_wd, "R1 R3 R4 R6 write_data", write_data, m_wd);
      check(bit_req == m_req, "R5 bit_req", bit_req, m_req);
    end
    if (spoil > 0) begin
      spoil--;
      if (spoil == 0) bit_in = ~bit_in;
    end
    if (bit_req) begin
      bit_in = pat[drv_idx % 64];
      drv_idx++;
      spoil = 2;
    end
  end

  task automatic cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic pulse_start;
    start = 1; cyc(1); start = 0;
  endtask

  task automatic pulse_stop;
    stop = 1; cyc(1); stop = 0;
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 5000 && write_gate; i++) cyc(1);
    check(!write_gate, "R7 return to idle", write_gate, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) pat[i] = ((i * 37 + (i >> 2)) % 5) < 2;
    pat[0] = 1; pat[1] = 1; pat[2] = 0;
    cyc(3);
    check(write_gate == 0, "R1 reset write_gate", write_gate, 0);
    check(write_data == 0, "R1 reset write_data", write_data, 0);
    check(bit_req == 0, "R1 reset bit_req", bit_req, 0);
    rst_n = 1;
    run_cmp = 1;
    cyc(4);
    pulse_stop;
    cyc(3);
    pulse_start;
    cyc(LEAD + 8 * CELL + 30);
    pulse_stop;
    wait_idle();
    cyc(20);
    pulse_start;
    cyc(LEAD + 3 * CELL);
    pulse_start;
    cyc(2 * CELL + 40);
    pulse_start;
    cyc(CELL + 10);
    pulse_stop;
    wait_idle();
    cyc(10);
    pulse_start;
    cyc(LEAD / 2);
    pulse_stop;
    cyc(2);
    check(write_gate == 0, "R7 stop in lead-in", write_gate, 0);
    cyc(10);
    start = 1; stop = 1; cyc(1); start = 0; stop = 0;
    check(write_gate == 1, "R7 R2 stop ignored when idle", write_gate, 1);
    cyc(LEAD + 5 * CELL - 1);
    pulse_stop;
    wait_idle();
    cyc(20);
    run_cmp = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule